// File: doc/BRIEF.md
# Burst Loop Activation Synchronizer

This per-line controller brings a burst-mode two-wire loop up from idle and holds it in frame synchronization. The same logic serves either end of the loop. An input bit selects master or slave operation. Line behaviour is modelled with abstract per-frame flags: `rx_burst` marks the arrival of a received burst, `rx_good` says that the burst was correctly formatted, and `tx_burst` is a one-cycle request for the transmitter to send one burst.

A master frames its work on `frame_sync`, the frame strobe at the full burst rate. A slave frames its work on `local_tick`, the strobe from its own oscillator. A master starts activation when software issues `act_cmd`, and it then sends a burst on every frame strobe. If a master sees line signal while idle, it only raises `wake_flag` and waits for `act_cmd`. A slave that sees line signal answers straight away, and it times each transmit burst to a received burst. A slave can also wake the loop itself with `act_cmd`: it then sends a burst on every second local tick, and it realigns to the master as soon as master bursts arrive. The good-frame run and the miss run decide when sync is declared and when it is lost. `deact_cmd` returns the block to idle from any state.

States: DEACT (idle), WAKE_TX (slave sending half-rate bursts), WAIT_ACT (master holding a wake-up), SEARCH, IN_SYNC. Transitions:
- DEACT→SEARCH on a master `act_cmd` or on slave line detect.
- DEACT→WAIT_ACT on master line detect.
- DEACT→WAKE_TX on a slave `act_cmd`.
- WAIT_ACT→SEARCH on `act_cmd`.
- WAKE_TX→SEARCH on the first received burst.
- SEARCH→IN_SYNC after GOOD_RUN good frames in a row.
- IN_SYNC→SEARCH after MISS_RUN missed frames in a row.
- any state→DEACT on `deact_cmd`, which has priority over every other input.

Top module: `loop_sync_ctrl`

## Requirements
- R1: After reset the block is in DEACT: `in_sync`, `sync_chg`, `wake_flag` and `tx_burst` are all 0, and no burst is sent for `frame_sync`, `local_tick` or `rx_burst`.
- R2: A master in DEACT moves to SEARCH on `act_cmd`. In SEARCH and in IN_SYNC it raises `tx_burst` for one cycle, in the cycle after each `frame_sync` pulse.
- R3: A master in DEACT that sees `line_det` while `act_cmd` is low moves to WAIT_ACT. There `wake_flag` is 1 and no burst is sent. The next `act_cmd` moves it to SEARCH and clears `wake_flag`.
- R4: A slave in DEACT that sees `line_det` moves to SEARCH. In SEARCH and in IN_SYNC, `tx_burst` follows each `rx_burst` by one cycle, and `local_tick` sends no burst.
- R5: A slave in DEACT moves to WAKE_TX on `act_cmd`. There it sends a burst one cycle after the 1st, 3rd, 5th and later odd-numbered `local_tick` pulses, and none after the even-numbered ones.
- R6: A slave in WAKE_TX moves to SEARCH on the first `rx_burst`. That first burst neither sends a burst nor counts as a good frame. From then on, transmit bursts follow received bursts.
- R7: The frame event is `frame_sync` for a master and `local_tick` for a slave. A frame is good when a burst with `rx_good`=1 arrived since the previous frame event. SEARCH moves to IN_SYNC at the GOOD_RUN-th consecutive good frame (default 4). A frame that is not good restarts the run.
- R8: IN_SYNC returns to SEARCH at the MISS_RUN-th consecutive frame that is not good (default 4). One good frame restarts the miss run.
- R9: `in_sync` changes in the cycle after the deciding frame event. `sync_chg` is 1 in exactly the cycles in which `in_sync` has changed, and 0 at all other times.
- R10: `deact_cmd` returns the block to DEACT from any state, and it overrides `act_cmd`. In the next cycle `tx_burst` is 0, `in_sync` and `wake_flag` are 0, and later strobes send no burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 = master end, 0 = slave end |
| act_cmd | input | 1 | Activate command pulse |
| deact_cmd | input | 1 | Deactivate command pulse |
| line_det | input | 1 | Line signal detected |
| frame_sync | input | 1 | Full-rate frame strobe (master timing) |
| local_tick | input | 1 | Local oscillator frame strobe (slave timing) |
| rx_burst | input | 1 | A burst was received this cycle |
| rx_good | input | 1 | The received burst was correctly formatted |
| tx_burst | output | 1 | One-cycle request to transmit a burst |
| in_sync | output | 1 | Loop sync status |
| sync_chg | output | 1 | One-cycle pulse on each change of `in_sync` |
| wake_flag | output | 1 | Master is holding a detected wake-up |

## Verification
The checker watches every cycle for the following:
- the `sync_chg` pulse against changes of `in_sync`;
- the quiet outputs after `deact_cmd`;
- the absence of bursts while a wake-up is held;
- a master burst that has no frame strobe before it;
- sync gained or lost outside a frame event.

Only the directed scenarios can show the rest:
- the run lengths: four good frames win sync, a bad frame restarts the run, and four misses lose sync;
- the alternating pattern of the slave wake-up;
- the realignment of a slave onto received bursts;
- the hold of a master until software activates it.

// File: rtl/lsync_pkg.sv
package lsync_pkg;
    typedef enum logic [2:0] {
        LS_DEACT    = 3'd0,
        LS_WAKE_TX  = 3'd1,
        LS_WAIT_ACT = 3'd2,
        LS_SEARCH   = 3'd3,
        LS_IN_SYNC  = 3'd4
    } lsync_state_e;
endpackage

// File: rtl/lsync_fsm.sv
module lsync_fsm
    import lsync_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         is_master,
    input  logic         act_cmd,
    input  logic         deact_cmd,
    input  logic         line_det,
    input  logic         rx_burst,
    input  logic         sync_hit,
    input  logic         loss_hit,
    output lsync_state_e state,
    output logic         in_sync,
    output logic         sync_chg,
    output logic         wake_flag
);
    lsync_state_e nxt;

    always_comb begin
        nxt = state;
        if (deact_cmd) begin
            nxt = LS_DEACT;
        end else begin
            unique case (state)
                LS_DEACT: begin
                    if (is_master) begin
                        if (act_cmd)       nxt = LS_SEARCH;
                        else if (line_det) nxt = LS_WAIT_ACT;
                    end else begin
                        if (act_cmd)       nxt = LS_WAKE_TX;
                        else if (line_det) nxt = LS_SEARCH;
                    end
                end
                LS_WAIT_ACT: if (act_cmd)  nxt = LS_SEARCH;
                LS_WAKE_TX:  if (rx_burst) nxt = LS_SEARCH;
                LS_SEARCH:   if (sync_hit) nxt = LS_IN_SYNC;
                LS_IN_SYNC:  if (loss_hit) nxt = LS_SEARCH;
                default:                   nxt = LS_DEACT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LS_DEACT;
        else        state <= nxt;
    end

    // registered status outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_sync   <= 1'b0;
            sync_chg  <= 1'b0;
            wake_flag <= 1'b0;
        end else begin
            in_sync   <= (nxt == LS_IN_SYNC);
            sync_chg  <= (nxt == LS_IN_SYNC) != (state == LS_IN_SYNC);
            wake_flag <= (nxt == LS_WAIT_ACT);
        end
    end
endmodule

// File: rtl/lsync_frame_judge.sv
module lsync_frame_judge
    import lsync_pkg::*;
#(
    parameter int GOOD_RUN = 4,
    parameter int MISS_RUN = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  lsync_state_e state,
    input  logic         frame_evt,
    input  logic         rx_burst,
    input  logic         rx_good,
    output logic         sync_hit,
    output logic         loss_hit
);
    localparam int GW = (GOOD_RUN > 2) ? $clog2(GOOD_RUN) : 1;
    localparam int MW = (MISS_RUN > 2) ? $clog2(MISS_RUN) : 1;
    localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_RUN - 1);
    localparam logic [MW-1:0] MISS_LAST = MW'(MISS_RUN - 1);

    logic          good_seen;
    logic          good_now;
    logic          tracking;
    logic [GW-1:0] good_cnt;
    logic [MW-1:0] miss_cnt;

    assign tracking = (state == LS_SEARCH) || (state == LS_IN_SYNC);
    assign good_now = good_seen || (rx_burst && rx_good);
    assign sync_hit = (state == LS_SEARCH)  && frame_evt &&  good_now && (good_cnt == GOOD_LAST);
    assign loss_hit = (state == LS_IN_SYNC) && frame_evt && !good_now && (miss_cnt == MISS_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_seen <= 1'b0;
        end else if (!tracking || frame_evt) begin
            good_seen <= 1'b0;
        end else if (rx_burst && rx_good) begin
            good_seen <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_cnt <= '0;
        end else if (state != LS_SEARCH) begin
            good_cnt <= '0;
        end else if (frame_evt) begin
            if (!good_now)                good_cnt <= '0;
            else if (good_cnt != GOOD_LAST) good_cnt <= good_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miss_cnt <= '0;
        end else if (state != LS_IN_SYNC) begin
            miss_cnt <= '0;
        end else if (frame_evt) begin
            if (good_now)                   miss_cnt <= '0;
            else if (miss_cnt != MISS_LAST) miss_cnt <= miss_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lsync_burst_gen.sv
module lsync_burst_gen
    import lsync_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  lsync_state_e state,
    input  logic         is_master,
    input  logic         frame_sync,
    input  logic         local_tick,
    input  logic         rx_burst,
    input  logic         deact_cmd,
    output logic         tx_burst
);
    logic half_phase;
    logic fire;

    always_comb begin
        fire = 1'b0;
        unique case (state)
            LS_WAKE_TX:             fire = local_tick && !half_phase;
            LS_SEARCH, LS_IN_SYNC:  fire = is_master ? frame_sync : rx_burst;
            default:                fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_phase <= 1'b0;
        end else if (state != LS_WAKE_TX) begin
            half_phase <= 1'b0;
        end else if (local_tick) begin
            half_phase <= !half_phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_burst <= 1'b0;
        else        tx_burst <= fire && !deact_cmd;
    end
endmodule

// File: rtl/loop_sync_ctrl.sv
module loop_sync_ctrl
    import lsync_pkg::*;
#(
    parameter int GOOD_RUN = 4,
    parameter int MISS_RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    input  logic act_cmd,
    input  logic deact_cmd,
    input  logic line_det,
    input  logic frame_sync,
    input  logic local_tick,
    input  logic rx_burst,
    input  logic rx_good,
    output logic tx_burst,
    output logic in_sync,
    output logic sync_chg,
    output logic wake_flag
);
    lsync_state_e state;
    logic         frame_evt;
    logic         sync_hit;
    logic         loss_hit;

    assign frame_evt = is_master ? frame_sync : local_tick;

    lsync_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (is_master),
        .act_cmd   (act_cmd),
        .deact_cmd (deact_cmd),
        .line_det  (line_det),
        .rx_burst  (rx_burst),
        .sync_hit  (sync_hit),
        .loss_hit  (loss_hit),
        .state     (state),
        .in_sync   (in_sync),
        .sync_chg  (sync_chg),
        .wake_flag (wake_flag)
    );

    lsync_frame_judge #(
        .GOOD_RUN (GOOD_RUN),
        .MISS_RUN (MISS_RUN)
    ) judge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .frame_evt (frame_evt),
        .rx_burst  (rx_burst),
        .rx_good   (rx_good),
        .sync_hit  (sync_hit),
        .loss_hit  (loss_hit)
    );

    lsync_burst_gen burst_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .is_master  (is_master),
        .frame_sync (frame_sync),
        .local_tick (local_tick),
        .rx_burst   (rx_burst),
        .deact_cmd  (deact_cmd),
        .tx_burst   (tx_burst)
    );
endmodule

// File: rtl/lsync_checker.sv
module lsync_checker (
    input logic clk,
    input logic rst_n,
    input logic is_master,
    input logic frame_sync,
    input logic local_tick,
    input logic deact_cmd,
    input logic tx_burst,
    input logic in_sync,
    input logic sync_chg,
    input logic wake_flag
);
    p_chg_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_chg == (in_sync != $past(in_sync)));

    p_deact_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        deact_cmd |=> (!tx_burst && !in_sync && !wake_flag));

    p_wake_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_flag |-> !tx_burst);

    p_master_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_burst && $past(is_master)) |-> $past(frame_sync));

    p_sync_on_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(is_master ? frame_sync : local_tick));

    p_loss_on_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(in_sync) && !$past(deact_cmd)) |-> $past(is_master ? frame_sync : local_tick));
endmodule

bind loop_sync_ctrl lsync_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_master  (is_master),
    .frame_sync (frame_sync),
    .local_tick (local_tick),
    .deact_cmd  (deact_cmd),
    .tx_burst   (tx_burst),
    .in_sync    (in_sync),
    .sync_chg   (sync_chg),
    .wake_flag  (wake_flag)
);

// File: tb/loop_sync_ctrl_tb_top.sv
`timescale 1ns/1ps
module loop_sync_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic is_master = 1'b1, act_cmd = 1'b0, deact_cmd = 1'b0, line_det = 1'b0;
    logic frame_sync = 1'b0, local_tick = 1'b0, rx_burst = 1'b0, rx_good = 1'b0;
    logic tx_burst, in_sync, sync_chg, wake_flag;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    loop_sync_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .act_cmd(act_cmd),
        .deact_cmd(deact_cmd), .line_det(line_det), .frame_sync(frame_sync),
        .local_tick(local_tick), .rx_burst(rx_burst), .rx_good(rx_good),
        .tx_burst(tx_burst), .in_sync(in_sync), .sync_chg(sync_chg),
        .wake_flag(wake_flag)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // one-cycle pulse helpers; outputs are sampled at the negedge after
    task automatic pulse_act();    act_cmd = 1;    step(); act_cmd = 0;    endtask
    task automatic pulse_deact();  deact_cmd = 1;  step(); deact_cmd = 0;  endtask
    task automatic pulse_fs();     frame_sync = 1; step(); frame_sync = 0; endtask
    task automatic pulse_lt();     local_tick = 1; step(); local_tick = 0; endtask
    task automatic pulse_rx(input logic g);
        rx_burst = 1; rx_good = g; step(); rx_burst = 0; rx_good = 0;
    endtask

    // master frame: optional received burst, then the frame strobe
    task automatic m_frame(input bit burst, input bit good);
        if (burst) pulse_rx(good); else step();
        pulse_fs();
    endtask

    // slave frame: optional received burst, then the local tick
    task automatic s_frame(input bit burst, input bit good);
        if (burst) pulse_rx(good); else step();
        pulse_lt();
    endtask

    task automatic t_reset();
        chk("R1 in_sync", in_sync, 0);
        chk("R1 sync_chg", sync_chg, 0);
        chk("R1 wake_flag", wake_flag, 0);
        pulse_fs();
        chk("R1 no tx on frame_sync", tx_burst, 0);
        pulse_rx(1);
        chk("R1 no tx on rx_burst", tx_burst, 0);
    endtask

    task automatic t_master_sync();
        is_master = 1;
        pulse_act();
        chk("R2 no tx at activate", tx_burst, 0);
        m_frame(1, 1);
        chk("R2 tx after frame_sync", tx_burst, 1);
        step();
        chk("R2 tx one cycle", tx_burst, 0);
        m_frame(1, 1);
        m_frame(1, 0);
        chk("R7 bad frame keeps search", in_sync, 0);
        m_frame(1, 1); m_frame(1, 1); m_frame(1, 1);
        chk("R7 three good not sync", in_sync, 0);
        m_frame(1, 1);
        chk("R7 fourth good -> sync", in_sync, 1);
        chk("R9 chg on sync", sync_chg, 1);
        step();
        chk("R9 chg one cycle", sync_chg, 0);
        m_frame(0, 0); m_frame(0, 0); m_frame(0, 0);
        chk("R8 three misses hold", in_sync, 1);
        m_frame(1, 1);
        m_frame(0, 0); m_frame(0, 0); m_frame(0, 0);
        chk("R8 miss run restarted", in_sync, 1);
        chk("R9 no chg while stable", sync_chg, 0);
        m_frame(0, 0);
        chk("R8 fourth miss -> loss", in_sync, 0);
        chk("R9 chg on loss", sync_chg, 1);
        chk("R2 tx in in_sync frame", tx_burst, 1);
        m_frame(0, 0);
        chk("R8 back to search tx", tx_burst, 1);
        pulse_deact();
    endtask

    task automatic t_master_wake();
        is_master = 1;
        line_det = 1; step(); line_det = 0;
        chk("R3 wake_flag set", wake_flag, 1);
        pulse_fs();
        chk("R3 no tx while waiting", tx_burst, 0);
        pulse_act();
        chk("R3 wake_flag cleared", wake_flag, 0);
        pulse_fs();
        chk("R3 tx after activate", tx_burst, 1);
        pulse_deact();
    endtask

    task automatic t_slave_answer();
        is_master = 0;
        line_det = 1; step(); line_det = 0;
        pulse_rx(1);
        chk("R4 tx follows rx", tx_burst, 1);
        pulse_lt();
        chk("R4 no tx on local_tick", tx_burst, 0);
        s_frame(1, 1); s_frame(1, 1); s_frame(1, 1);
        chk("R7 slave four good -> sync", in_sync, 1);
        chk("R9 slave chg", sync_chg, 1);
        pulse_deact();
        chk("R10 deact drops sync", in_sync, 0);
        chk("R10 deact chg", sync_chg, 1);
        chk("R10 tx quiet", tx_burst, 0);
        pulse_rx(1);
        chk("R10 no tx after deact", tx_burst, 0);
    endtask

    task automatic t_slave_wake();
        is_master = 0;
        pulse_act();
        pulse_lt(); chk("R5 tick1 tx", tx_burst, 1);
        pulse_lt(); chk("R5 tick2 quiet", tx_burst, 0);
        pulse_lt(); chk("R5 tick3 tx", tx_burst, 1);
        pulse_lt(); chk("R5 tick4 quiet", tx_burst, 0);
        pulse_rx(1);
        chk("R6 first rx sends nothing", tx_burst, 0);
        pulse_lt();
        chk("R6 local_tick no tx after realign", tx_burst, 0);
        pulse_rx(1);
        chk("R6 tx follows rx", tx_burst, 1);
        pulse_lt(); s_frame(1, 1); s_frame(1, 1);
        chk("R6 first rx not counted", in_sync, 0);
        s_frame(1, 1);
        chk("R7 sync after realign", in_sync, 1);
        is_master = 0;
        act_cmd = 1; deact_cmd = 1; step(); act_cmd = 0; deact_cmd = 0;
        chk("R10 deact wins over act", in_sync, 0);
        pulse_lt();
        chk("R10 no wake burst after deact", tx_burst, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_master_sync();
        t_master_wake();
        t_slave_answer();
        t_slave_wake();
        repeat (3) step();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule